// File: doc/BRIEF.md
# Slew-Limited Waveform Generator

This block drives an unsigned DAC code that travels between a programmable low-limit code and a programmable high-limit code. A 2-bit shape selector picks one of four periodic patterns: a triangle, a sawtooth that climbs in steps and drops at once, a sawtooth that falls in steps and rises at once, or a square wave. A 3-bit field sets how many LSBs each step moves. A 4-bit field sets how many clock cycles pass between steps. One setting of the interval field turns the stepping off, so every step lands on the target limit in a single clock.

The output is the present code plus a one-cycle strobe that marks each code change. A downstream converter interface can latch the code on that strobe. Dropping the enable, or changing the shape, step or interval selection, restarts the pattern at the low limit with the direction set upward. The interval table assumes a 10 MHz clock by default. The clock rate is a parameter, and every interval count is derived from it.

Top module: `wavegen_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `code` is 0 and `upd` is 0.
- R2: If `en` is low, or if `{wave_mode, step_sel, rate_sel}` differs from its value one cycle earlier, then on the next clock `code` takes the low limit (or the high limit if the limits are degenerate), the direction becomes upward, and the step timer reloads.
- R3: `rate_sel` sets the cycles between steps at 10 MHz. 0000..1011 give 256, 320, 384, 448, 2048, 2560, 3072, 8192, 16384, 24576, 32768 and 49152 cycles. 1100, 1101 and 1110 give 120, 80 and 40 cycles. The first step comes that many cycles after a restart.
- R4: `step_sel` 000..111 gives a step of 1, 2, 3, 4, 6, 8, 16 or 32 LSB.
- R5: Triangle (`wave_mode` 00) climbs by the step to the high limit and then descends by the step to the low limit, and repeats.
- R6: Rising sawtooth (01) climbs by the step. On the step after it reaches the high limit, it returns to the low limit.
- R7: Falling sawtooth (10) starts at the low limit and jumps to the high limit on its first step. It then descends by the step, and once at the low limit it jumps back to the high limit.
- R8: Square (11) alternates between the two limits, starting at the low limit and going high first. Each level lasts one interval.
- R9: `rate_sel` 1111 (the reset setting) makes a step on every clock. Each step moves straight to the target limit, so every shape toggles between the limits on each clock.
- R10: If `lim_lo` is not below `lim_hi`, `code` holds `lim_hi` and no stepping happens.
- R11: `upd` is high for exactly the cycles in which `code` differs from its value in the previous cycle.
- R12: A step that would pass a limit stops on that limit, and this holds for codes near the top of the code range as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the pattern at its start point |
| lim_hi | input | CODE_W | High-limit code |
| lim_lo | input | CODE_W | Low-limit code |
| wave_mode | input | 2 | Shape: 00 triangle, 01 rising saw, 10 falling saw, 11 square |
| step_sel | input | 3 | Step-size selector |
| rate_sel | input | 4 | Step-interval selector, 1111 = no slew |
| code | output | CODE_W | Present DAC code |
| upd | output | 1 | One-cycle strobe on each code change |

## Verification
A fault in the step timer shows as a code change one or more cycles off the interval grid. A stuck direction bit shows up at the first limit turn of a triangle, because the code climbs again or clamps twice. Bad clamp arithmetic puts a code outside the limits, or a step of the wrong size, on the first step that crosses a limit. The bench compares `code` and `upd` against a behavioural model on every clock, so each of these faults is reported in the cycle where it first reaches the ports.

// File: rtl/wg_pkg.sv
package wg_pkg;

  typedef enum logic [1:0] {
    WG_TRI     = 2'b00,
    WG_SAW_UP  = 2'b01,
    WG_SAW_DN  = 2'b10,
    WG_SQUARE  = 2'b11
  } wg_mode_e;

  localparam logic [3:0] RATE_NOSLEW = 4'hF;
  localparam int unsigned STEP_W = 6;

  // Step increment in LSB for each step-size selector value.
  function automatic logic [STEP_W-1:0] step_lsb(input logic [2:0] sel);
    logic [STEP_W-1:0] r;
    case (sel)
      3'd0: r = 6'd1;
      3'd1: r = 6'd2;
      3'd2: r = 6'd3;
      3'd3: r = 6'd4;
      3'd4: r = 6'd6;
      3'd5: r = 6'd8;
      3'd6: r = 6'd16;
      default: r = 6'd32;
    endcase
    return r;
  endfunction

  // Step interval in tenths of a microsecond; 0 marks the no-slew code.
  function automatic int unsigned interval_tenths(input logic [3:0] sel);
    int unsigned t;
    case (sel)
      4'h0: t = 256;
      4'h1: t = 320;
      4'h2: t = 384;
      4'h3: t = 448;
      4'h4: t = 2048;
      4'h5: t = 2560;
      4'h6: t = 3072;
      4'h7: t = 8192;
      4'h8: t = 16384;
      4'h9: t = 24576;
      4'hA: t = 32768;
      4'hB: t = 49152;
      4'hC: t = 120;
      4'hD: t = 80;
      4'hE: t = 40;
      default: t = 0;
    endcase
    return t;
  endfunction

  // Clock cycles per step at a given clock rate, at least one.
  function automatic int unsigned interval_ticks(input logic [3:0] sel,
                                                 input int unsigned clk_mhz);
    int unsigned c;
    c = (interval_tenths(sel) * clk_mhz) / 10;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/wg_step_decode.sv
module wg_step_decode #(
  parameter int unsigned CLK_MHZ = 10,
  parameter int unsigned CNT_W   = 16
) (
  input  logic [2:0]                 step_sel,
  input  logic [3:0]                 rate_sel,
  output logic [wg_pkg::STEP_W-1:0]  step_amt,
  output logic [CNT_W-1:0]           reload,
  output logic                       no_slew
);
  localparam int unsigned NSEL = 16;

  logic [CNT_W-1:0] reload_tab [NSEL];

  for (genvar i = 0; i < NSEL; i++) begin : g_tab
    assign reload_tab[i] = CNT_W'(wg_pkg::interval_ticks(4'(i), CLK_MHZ) - 1);
  end

  always_comb begin
    step_amt = wg_pkg::step_lsb(step_sel);
    reload   = reload_tab[rate_sel];
    no_slew  = (rate_sel == wg_pkg::RATE_NOSLEW);
  end

endmodule

// File: rtl/wg_step_timer.sv
module wg_step_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    tick    = !restart && at_zero;
    if (restart || at_zero) cnt_d = reload;
    else                    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The counter only ever moves down by one between reloads.
  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wg_seq.sv
module wg_seq #(
  parameter int unsigned CODE_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  input  logic                      tick,
  input  wg_pkg::wg_mode_e          mode,
  input  logic [wg_pkg::STEP_W-1:0] step_amt,
  input  logic                      no_slew,
  input  logic [CODE_W-1:0]         lim_lo,
  input  logic [CODE_W-1:0]         lim_hi,
  output logic [CODE_W-1:0]         code,
  output logic                      upd
);
  import wg_pkg::*;

  localparam int unsigned EXT_W = CODE_W + STEP_W + 1;

  logic [CODE_W-1:0] code_q, code_d;
  logic              up_q, up_d;
  logic              upd_q, upd_d;
  logic [EXT_W-1:0]  code_x, lo_x, hi_x, step_x;
  logic [EXT_W-1:0]  sum_x;
  logic              reach_hi, reach_lo, lim_ok;
  logic [CODE_W-1:0] inc_code, dec_code;

  always_comb begin
    code_x   = EXT_W'(code_q);
    lo_x     = EXT_W'(lim_lo);
    hi_x     = EXT_W'(lim_hi);
    step_x   = EXT_W'(step_amt);
    sum_x    = code_x + step_x;
    lim_ok   = (lim_lo < lim_hi);
    reach_hi = no_slew || (sum_x >= hi_x);
    reach_lo = no_slew || (code_x <= lo_x + step_x);
    inc_code = reach_hi ? lim_hi : CODE_W'(sum_x);
    dec_code = reach_lo ? lim_lo : CODE_W'(code_x - step_x);
  end

  always_comb begin
    code_d = code_q;
    up_d   = up_q;
    if (restart) begin
      code_d = lim_ok ? lim_lo : lim_hi;
      up_d   = 1'b1;
    end else if (tick) begin
      case (mode)
        WG_TRI: begin
          if (up_q) begin
            code_d = inc_code;
            if (reach_hi) up_d = 1'b0;
          end else begin
            code_d = dec_code;
            if (reach_lo) up_d = 1'b1;
          end
        end
        WG_SAW_UP: code_d = (code_q >= lim_hi) ? lim_lo : inc_code;
        WG_SAW_DN: code_d = (code_q <= lim_lo) ? lim_hi : dec_code;
        default:   code_d = (code_q >= lim_hi) ? lim_lo : lim_hi;
      endcase
    end
    upd_d = (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      up_q   <= 1'b1;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      up_q   <= up_d;
      upd_q  <= upd_d;
    end
  end

  assign code = code_q;
  assign upd  = upd_q;

  assert_step_in_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim_ok && code_q >= lim_lo && code_q <= lim_hi)
      |=> (code_q >= $past(lim_lo) && code_q <= $past(lim_hi)));

  assert_restart_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (code_q == ($past(lim_lo < lim_hi) ? $past(lim_lo) : $past(lim_hi))));

  assert_quiet_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(code_q));

  assert_tri_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WG_TRI && up_q && !no_slew && (sum_x < hi_x))
      |=> (EXT_W'(code_q) == EXT_W'($past(code_q)) + EXT_W'($past(step_amt))));

  assert_square_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == WG_SQUARE)
      |=> (code_q == $past(lim_lo) || code_q == $past(lim_hi)));

endmodule

// File: rtl/wavegen_top.sv
module wavegen_top #(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned CLK_MHZ = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] lim_hi,
  input  logic [CODE_W-1:0] lim_lo,
  input  logic [1:0]        wave_mode,
  input  logic [2:0]        step_sel,
  input  logic [3:0]        rate_sel,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  import wg_pkg::*;

  localparam int unsigned MAX_TICKS = (49152 * CLK_MHZ) / 10;
  localparam int unsigned CNT_W     = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;
  localparam int unsigned CFG_W     = 2 + 3 + 4;
  localparam logic [CFG_W-1:0] CFG_RST = {2'b00, 3'b000, RATE_NOSLEW};

  logic [CFG_W-1:0]  cfg_now, cfg_q;
  logic              cfg_chg, degen, restart, tick, no_slew;
  logic [STEP_W-1:0] step_amt;
  logic [CNT_W-1:0]  reload;

  always_comb begin
    cfg_now = {wave_mode, step_sel, rate_sel};
    cfg_chg = (cfg_now != cfg_q);
    degen   = (lim_lo >= lim_hi);
    restart = !en || cfg_chg || degen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_now;
  end

  wg_step_decode #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_decode (
    .step_sel (step_sel),
    .rate_sel (rate_sel),
    .step_amt (step_amt),
    .reload   (reload),
    .no_slew  (no_slew)
  );

  wg_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .reload  (reload),
    .tick    (tick)
  );

  wg_seq #(.CODE_W(CODE_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .tick     (tick),
    .mode     (wg_mode_e'(wave_mode)),
    .step_amt (step_amt),
    .no_slew  (no_slew),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi),
    .code     (code),
    .upd      (upd)
  );

  assert_degen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_lo >= lim_hi) |=> (code == $past(lim_hi)));

endmodule

// File: tb/tb_wavegen_top.sv
module tb_wavegen_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] lim_hi = '0;
  logic [W-1:0] lim_lo = '0;
  logic [1:0]   wave_mode = 2'b00;
  logic [2:0]   step_sel = 3'b000;
  logic [3:0]   rate_sel = 4'hF;
  logic [W-1:0] code;
  logic         upd;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  wavegen_top #(.CODE_W(W), .CLK_MHZ(10)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .wave_mode(wave_mode), .step_sel(step_sel), .rate_sel(rate_sel),
    .code(code), .upd(upd)
  );

  function automatic int ref_step(input int s);
    int tbl[8] = '{1, 2, 3, 4, 6, 8, 16, 32};
    return tbl[s];
  endfunction

  function automatic int ref_cycles(input int r);
    int tbl[16] = '{256, 320, 384, 448, 2048, 2560, 3072, 8192, 16384,
                    24576, 32768, 49152, 120, 80, 40, 1};
    return tbl[r];
  endfunction

  // Behavioural reference model
  int m_code = 0;
  int m_left = 0;
  bit m_up = 1;
  bit m_upd = 0;
  int m_cfg = 'h0F;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_left = 0; m_up = 1; m_upd = 0; m_cfg = 'h0F;
    end else begin
      int cfg, nc, lo, hi, s;
      bit chg;
      lo  = lim_lo; hi = lim_hi;
      cfg = {wave_mode, step_sel, rate_sel};
      chg = (cfg != m_cfg);
      m_cfg = cfg;
      nc = m_code;
      if (!en || chg || lo >= hi) begin
        nc = (lo < hi) ? lo : hi;
        m_up = 1;
        m_left = ref_cycles(rate_sel) - 1;
      end else if (m_left > 0) begin
        m_left--;
      end else begin
        m_left = ref_cycles(rate_sel) - 1;
        s = (rate_sel == 4'hF) ? 100000 : ref_step(step_sel);
        case (wave_mode)
          2'b00: if (m_up) begin
                   if (m_code + s >= hi) begin nc = hi; m_up = 0; end
                   else nc = m_code + s;
                 end else begin
                   if (m_code - s <= lo) begin nc = lo; m_up = 1; end
                   else nc = m_code - s;
                 end
          2'b01: nc = (m_code >= hi) ? lo : ((m_code + s >= hi) ? hi : m_code + s);
          2'b10: nc = (m_code <= lo) ? hi : ((m_code - s <= lo) ? lo : m_code - s);
          default: nc = (m_code >= hi) ? lo : hi;
        endcase
      end
      m_upd = (nc != m_code);
      m_code = nc;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (int'(code) != m_code || upd != m_upd) begin
        bad++;
        $display("FAIL %s: code=%0d upd=%0b expected code=%0d upd=%0b at %0t",
                 tag, code, upd, m_code, m_upd, $time);
      end
    end
  end

  task automatic setup(input string t, input int lo, input int hi, input int md,
                       input int st, input int rt, input int cycles);
    @(negedge clk);
    tag = t;
    lim_lo = W'(lo); lim_hi = W'(hi);
    wave_mode = 2'(md); step_sel = 3'(st); rate_sel = 4'(rt);
    en = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (code !== '0 || upd !== 1'b0) begin
      bad++;
      $display("FAIL R1: code=%0d upd=%0b expected code=0 upd=0", code, upd);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (code !== '0 || upd !== 1'b0) begin
      bad++;
      $display("FAIL R1: after release code=%0d upd=%0b expected code=0 upd=0", code, upd);
    end
    setup("R5 R3 R4 R11 triangle step4 40cyc", 100, 140, 0, 3, 14, 1200);
    setup("R12 R5 triangle step6 clamp 80cyc", 100, 140, 0, 4, 13, 1500);
    setup("R12 triangle top of range step32", 990, 1023, 0, 7, 14, 600);
    setup("R6 rising saw step8 120cyc", 10, 50, 1, 5, 12, 1500);
    setup("R6 R12 rising saw step3 clamp", 10, 20, 1, 2, 14, 900);
    setup("R7 falling saw step16", 0, 100, 2, 6, 14, 900);
    setup("R7 R12 falling saw step32 near top", 1000, 1023, 2, 7, 13, 700);
    setup("R8 square 256cyc", 200, 700, 3, 0, 0, 1600);
    setup("R3 interval 320", 0, 5, 0, 0, 1, 1400);
    setup("R3 interval 384", 0, 5, 0, 1, 2, 1200);
    setup("R3 interval 448", 0, 5, 0, 0, 3, 1400);
    setup("R3 interval 2048", 0, 3, 1, 0, 4, 7000);
    setup("R4 step 1", 50, 58, 0, 0, 14, 900);
    setup("R9 noslew triangle", 5, 900, 0, 3, 15, 40);
    setup("R9 noslew square", 5, 900, 3, 3, 15, 40);
    setup("R9 noslew rising saw", 5, 900, 1, 6, 15, 40);
    setup("R9 noslew falling saw", 5, 900, 2, 6, 15, 40);
    setup("R10 equal limits", 200, 200, 0, 0, 14, 200);
    setup("R10 inverted limits", 300, 100, 3, 0, 14, 200);
    setup("R2 pre-disable run", 100, 400, 0, 6, 14, 500);
    @(negedge clk); tag = "R2 disable"; en = 1'b0;
    repeat (30) @(negedge clk);
    en = 1'b1; tag = "R2 re-enable";
    repeat (300) @(negedge clk);
    tag = "R2 config change"; step_sel = 3'd5;
    repeat (300) @(negedge clk);
    tag = "R2 mode change"; wave_mode = 2'b10;
    repeat (300) @(negedge clk);
    tag = "R2 limits change mid-run"; lim_hi = W'(250);
    repeat (400) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule